// File: doc/BRIEF.md
# Scrolling and Mirrored Row Mapper

This block translates the index of a display row output into the RAM row that must drive it. A display refresh scanner presents a row index every lookup, and the block answers, in the same cycle, with the RAM row index together with that row split into a page number and a bit position inside the page. Two held settings steer the translation: a scroll offset that names the RAM row shown at the anchor display row, and a mirror flag that reverses the direction in which display rows walk through RAM.

With the mirror flag clear, the anchor is display row 0 and successive display rows take successive RAM rows, wrapping at the row count. With the flag set, the anchor moves to the last display row and successive RAM rows are taken by display rows counting downward. Neither setting touches RAM; they only redirect the lookup, so a new offset or flag is seen on the very next lookup after the write. An offset write that names a row past the last one is refused and the previous offset stays in force.

Top module: `row_scroll_mapper`

## Requirements
- R1: After reset the scroll offset is 0 and the mirror flag is 0, so `ram_row` equals `disp_row` for every display row.
- R2: With the mirror flag at 0, `ram_row` = (offset + `disp_row`) mod 48; display row 0 shows the RAM row equal to the offset.
- R3: With the mirror flag at 1, `ram_row` = (offset + 47 − `disp_row`) mod 48; display row 47 shows the RAM row equal to the offset and display row 46 the next RAM row.
- R4: `ram_page` equals `ram_row` / 8 and `ram_bit` equals `ram_row` mod 8, bit 0 being the top row of a page.
- R5: A pulse on `scroll_wr` with `scroll_wdata` in 0..47 loads the offset, and every lookup from the following clock cycle on uses it.
- R6: A pulse on `scroll_wr` with `scroll_wdata` in 48..63 is ignored; the mapping keeps the previous offset.
- R7: A pulse on `mirror_wr` loads `mirror_wdata` into the mirror flag, used by every lookup from the following cycle on.
- R8: Offset and mirror writes in the same cycle both take effect together on the next cycle.
- R9: The lookup is combinational: a change of `disp_row` changes `ram_row`, `ram_page` and `ram_bit` within the same cycle, with no register in the path.
- R10: `ram_row` always lies in 0..47 for any display row in 0..47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held settings |
| rst_n | input | 1 | Active-low synchronous reset |
| scroll_wr | input | 1 | Write strobe for the scroll offset |
| scroll_wdata | input | 6 | New scroll offset |
| mirror_wr | input | 1 | Write strobe for the mirror flag |
| mirror_wdata | input | 1 | New mirror flag value |
| disp_row | input | 6 | Display row index from the scanner, 0..47 |
| ram_row | output | 6 | RAM row that drives the display row |
| ram_page | output | 3 | Page holding that RAM row |
| ram_bit | output | 3 | Bit position of the row within the page |

## Verification
The bench builds the block with its default 48 rows and 8-row pages, which keeps the full space of offset, mirror flag and display row small enough to sweep completely, so every wrap point at both anchors is visited. Because 48 is not a power of two, the 6-bit offset input can carry the values 48..63, which brings the refused-write case within reach. Random mixes of valid writes, refused writes, simultaneous writes and lookups then test how settings carry from one cycle to the next.

// File: rtl/row_scroll_mapper.sv
module row_scroll_mapper #(
  parameter int ROWS   = 48,
  parameter int PAGE_H = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        scroll_wr,
  input  logic [$clog2(ROWS)-1:0]                     scroll_wdata,
  input  logic                                        mirror_wr,
  input  logic                                        mirror_wdata,
  input  logic [$clog2(ROWS)-1:0]                     disp_row,
  output logic [$clog2(ROWS)-1:0]                     ram_row,
  output logic [$clog2(ROWS)-$clog2(PAGE_H)-1:0]      ram_page,
  output logic [$clog2(PAGE_H)-1:0]                   ram_bit
);

  localparam int RW = $clog2(ROWS);
  localparam int BW = $clog2(PAGE_H);
  localparam logic [RW:0]   ROWS_W = (RW+1)'(ROWS);
  localparam logic [RW-1:0] LAST_R = RW'(ROWS - 1);

  logic [RW-1:0] z_q;
  logic          my_q;
  logic          z_ok;
  logic [RW-1:0] step;
  logic [RW:0]   sum;

  assign z_ok = ({1'b0, scroll_wdata} < ROWS_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z_q  <= '0;
      my_q <= 1'b0;
    end else begin
      if (scroll_wr && z_ok) z_q <= scroll_wdata;
      if (mirror_wr)         my_q <= mirror_wdata;
    end
  end

  assign step     = my_q ? (LAST_R - disp_row) : disp_row;
  assign sum      = {1'b0, z_q} + {1'b0, step};
  assign ram_row  = (sum >= ROWS_W) ? RW'(sum - ROWS_W) : sum[RW-1:0];
  assign ram_page = ram_row[RW-1:BW];
  assign ram_bit  = ram_row[BW-1:0];

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, disp_row} < ROWS_W) |-> ({1'b0, ram_row} < ROWS_W));  // R10
  AST_ANCHOR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!my_q && disp_row == '0) |-> (ram_row == z_q));  // R2
  AST_ANCHOR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (my_q && disp_row == LAST_R) |-> (ram_row == z_q));  // R3
  AST_BAD_Z_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_wr && !z_ok) |=> $stable(z_q));  // R6
  AST_GOOD_Z_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_wr && z_ok) |=> (z_q == $past(scroll_wdata)));  // R5
  AST_MY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_wr |=> (my_q == $past(mirror_wdata)));  // R7

endmodule

// File: tb/tb_row_scroll_mapper.sv
module tb_row_scroll_mapper;
  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scroll_wr = 1'b0;
  logic [5:0] scroll_wdata = '0;
  logic       mirror_wr = 1'b0;
  logic       mirror_wdata = 1'b0;
  logic [5:0] disp_row = '0;
  logic [5:0] ram_row;
  logic [2:0] ram_page;
  logic [2:0] ram_bit;

  int checks = 0;
  int fails = 0;
  int mz = 0;
  int mmy = 0;

  always #(CYC/2) clk = ~clk;

  row_scroll_mapper dut (
    .clk(clk), .rst_n(rst_n),
    .scroll_wr(scroll_wr), .scroll_wdata(scroll_wdata),
    .mirror_wr(mirror_wr), .mirror_wdata(mirror_wdata),
    .disp_row(disp_row), .ram_row(ram_row),
    .ram_page(ram_page), .ram_bit(ram_bit)
  );

  function automatic int exp_row(int z, int my, int r);
    return (z + (my != 0 ? 47 - r : r)) % 48;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(string req, int r);
    int e;
    disp_row = 6'(r);
    #2;
    e = exp_row(mz, mmy, r);
    check(req, int'(ram_row), e);
    check("R4", int'(ram_page), e / 8);
    check("R4", int'(ram_bit), e % 8);
  endtask

  task automatic wr(bit do_z, int zv, bit do_m, int mv);
    @(negedge clk);
    scroll_wr = do_z; scroll_wdata = 6'(zv);
    mirror_wr = do_m; mirror_wdata = mv[0];
    @(negedge clk);
    scroll_wr = 1'b0; mirror_wr = 1'b0;
    if (do_z && zv < 48) mz = zv;
    if (do_m) mmy = mv & 1;
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 48; r++) look("R1", r);

    wr(1, 31, 0, 0);
    look("R5", 0);
    look("R2", 1);
    look("R2", 16);
    look("R2", 17);
    wr(1, 50, 0, 0);
    look("R6", 0);
    wr(1, 63, 0, 0);
    look("R6", 5);
    wr(1, 48, 0, 0);
    look("R6", 47);
    wr(0, 0, 1, 1);
    look("R7", 47);
    look("R3", 46);
    look("R3", 0);
    wr(1, 10, 1, 0);
    look("R8", 0);
    look("R8", 47);

    @(negedge clk);
    look("R9", 3);
    look("R9", 40);
    look("R9", 21);

    for (int my = 0; my < 2; my++)
      for (int z = 0; z < 48; z++) begin
        wr(1, z, 1, my);
        @(negedge clk);
        for (int r = 0; r < 48; r++) look(my != 0 ? "R3" : "R2", r);
      end

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: wr(1, int'($urandom_range(0, 47)), 0, 0);
        1: wr(1, int'($urandom_range(48, 63)), 0, 0);
        2: wr(0, 0, 1, int'($urandom_range(0, 1)));
        3: wr(1, int'($urandom_range(0, 63)), 1, int'($urandom_range(0, 1)));
        default: @(negedge clk);
      endcase
      look("R10", int'($urandom_range(0, 47)));
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mz = 0; mmy = 0;
    look("R1", 0);
    look("R1", 47);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule